// File: doc/BRIEF.md
# Two-Channel Interleaved Second-Order MASH Modulator

This block is a digital delta-sigma modulator of the cascaded 1-1 kind. It runs two sample channels side by side on a clock at half the sample rate. In every half-rate cycle it takes one pair of unsigned inputs of `W` bits: `x0` is the even sample and `x1` is the odd sample. For each channel it returns a small signed code whose long-run average follows `x / 2^W`.

The first accumulator integrates the input samples. It works in two steps inside each cycle: channel 0 first, then channel 1 on channel 0's result. The second accumulator integrates the residues of the first one, using the same two-step arrangement, one register stage later. The carries of the first stage are delayed by that same stage. A cancellation network then forms each channel's code from the two carries and the previous second-stage carry. Because the channels alternate, the previous sample of channel 0 is channel 1 of the cycle before.

A selector driven by the half-rate clock level turns the two channel codes into a single full-rate stream. This stream is what a downstream converter would sample.

Top module: `mash2_interleaved`

## Requirements
- R1: The first accumulator holds `W` bits. It adds `x0` and then `x1` modulo `2^W` in each cycle. Each addition that wraps gives a carry of 1 for that channel.
- R2: The second accumulator adds the `W`-bit residue left after each first-stage addition, modulo `2^W`. It does this in sample order, channel 0 before channel 1. Each wrap gives a second-stage carry.
- R3: A channel's code is c1 + c2 − c2_prev. For channel 1, c2_prev is channel 0's second-stage carry of the same cycle. For channel 0, it is channel 1's second-stage carry of the previous cycle.
- R4: `y0` and `y1` are signed two's-complement 3-bit codes and always lie in −1 to +2.
- R5: An input pair captured at rising edge k appears on `y0`/`y1` after rising edge k+1. The result matches a serial reference that processes x0 before x1.
- R6: While `clk` is high, `y_full` equals `y0`. While `clk` is low, it equals `y1`.
- R7: `out_valid` is 0 during reset and after the first edge following release. It is 1 from the second edge onward, and stays 1 until the next reset.
- R8: A synchronous reset clears both accumulators, the delayed carries and the previous-carry term. Outputs are 0 after a reset edge. A run started after a reset in the middle of operation matches a reference started from zero.
- R9: With equal inputs on both channels, the output sequence equals a serial modulator that repeats each input sample twice.
- R10: For a constant input K, the sum of 2·M consecutive codes is within 3 of K·2M / 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock; its level also steers the output selector |
| rst | input | 1 | Synchronous active-high reset |
| x0 | input | W | Even (channel 0) input sample, unsigned |
| x1 | input | W | Odd (channel 1) input sample, unsigned |
| y0 | output | 3 | Channel 0 code, signed |
| y1 | output | 3 | Channel 1 code, signed |
| y_full | output | 3 | Full-rate serialized code |
| out_valid | output | 1 | High when y0/y1 hold a code derived from real input |

## Verification
Each result of an input pair driven before rising edge k is due on `y0`/`y1` after edge k+1. The bench drives inputs at falling edges and compares, at the falling edge two cycles later, against a serial model's codes stored by sample index. `out_valid` is checked low one falling edge after reset release and high at the next one. The full-rate stream is sampled in the low phase and again a quarter period after a rising edge, so that each channel is seen in its own half of the cycle.

// File: rtl/mash2_interleaved.sv
module mash2_interleaved #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [W-1:0]        x0,
  input  logic [W-1:0]        x1,
  output logic signed [2:0]   y0,
  output logic signed [2:0]   y1,
  output logic signed [2:0]   y_full,
  output logic                out_valid
);
  localparam int OW = 3;

  logic [W-1:0] acc1, acc2, res0_q, res1_q;
  logic         c1a_q, c1b_q, c2_prev;
  logic [1:0]   vpipe;

  wire [W:0] s1a = {1'b0, acc1} + {1'b0, x0};
  wire [W:0] s1b = {1'b0, s1a[W-1:0]} + {1'b0, x1};
  wire [W:0] s2a = {1'b0, acc2} + {1'b0, res0_q};
  wire [W:0] s2b = {1'b0, s2a[W-1:0]} + {1'b0, res1_q};

  wire [OW-1:0] code0 = OW'(c1a_q) + OW'(s2a[W]) - OW'(c2_prev);
  wire [OW-1:0] code1 = OW'(c1b_q) + OW'(s2b[W]) - OW'(s2a[W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc1    <= '0;
      acc2    <= '0;
      res0_q  <= '0;
      res1_q  <= '0;
      c1a_q   <= 1'b0;
      c1b_q   <= 1'b0;
      c2_prev <= 1'b0;
      y0      <= '0;
      y1      <= '0;
      vpipe   <= '0;
    end else begin
      acc1    <= s1b[W-1:0];
      res0_q  <= s1a[W-1:0];
      res1_q  <= s1b[W-1:0];
      c1a_q   <= s1a[W];
      c1b_q   <= s1b[W];
      acc2    <= s2b[W-1:0];
      c2_prev <= s2b[W];
      y0      <= $signed(code0);
      y1      <= $signed(code1);
      vpipe   <= {vpipe[0], 1'b1};
    end
  end

  assign out_valid = vpipe[1];
  assign y_full    = clk ? y0 : y1;
endmodule

module mash2_interleaved_chk (
  input logic              clk,
  input logic              rst,
  input logic signed [2:0] y0,
  input logic signed [2:0] y1,
  input logic signed [2:0] y_full,
  input logic              out_valid
);
  assert_code_range_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (y0 >= -3'sd1 && y0 <= 3'sd2 && y1 >= -3'sd1 && y1 <= 3'sd2));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (y0 == 3'sd0 && y1 == 3'sd0 && !out_valid));

  assert_valid_holds_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  assert_low_phase_ch1_R6: assert property (@(posedge clk) disable iff (rst)
    y_full == y1);
endmodule

bind mash2_interleaved mash2_interleaved_chk u_chk (
  .clk(clk), .rst(rst), .y0(y0), .y1(y1), .y_full(y_full), .out_valid(out_valid)
);

// File: tb/mash2_interleaved_test.sv
`timescale 1ns/1ps
module mash2_interleaved_test;
  localparam int W = 12;
  localparam int FS = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] x0 = '0, x1 = '0;
  logic signed [2:0] y0, y1, y_full;
  logic out_valid;

  int checks = 0, errors = 0;
  int ra1, ra2, rc2p;
  int e0 [0:4095];
  int e1 [0:4095];

  mash2_interleaved #(.W(W)) uut (
    .clk(clk), .rst(rst), .x0(x0), .x1(x1),
    .y0(y0), .y1(y1), .y_full(y_full), .out_valid(out_valid)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_step(input int x);
    int c1, c2, y;
    ra1 = ra1 + x;  c1 = ra1 / FS; ra1 = ra1 % FS;
    ra2 = ra2 + ra1; c2 = ra2 / FS; ra2 = ra2 % FS;
    y = c1 + c2 - rc2p;
    rc2p = c2;
    return y;
  endfunction

  task automatic do_reset();
    rst = 1'b1; x0 = '0; x1 = '0;
    repeat (2) @(negedge clk);
    check("R8 y0 reset", int'(y0), 0);
    check("R8 y1 reset", int'(y1), 0);
    check("R7 valid in reset", int'(out_valid), 0);
    ra1 = 0; ra2 = 0; rc2p = 0;
    rst = 1'b0;
  endtask

  // mode 0 random, 1 equal channels, 2 ramp, 3 extremes
  task automatic run_seq(input int n, input int mode, input string tag);
    for (int i = 0; i < n + 2; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1) check({tag, " R7 valid not yet"}, int'(out_valid), 0);
      if (i >= 2) begin
        check({tag, " R7 valid"}, int'(out_valid), 1);
        check({tag, " R3 R5 y0"}, int'(y0), e0[i-2]);
        check({tag, " R3 R5 y1"}, int'(y1), e1[i-2]);
        check({tag, " R6 low phase"}, int'(y_full), int'(y1));
        if (y0 < -1 || y0 > 2) check({tag, " R4 y0 range"}, int'(y0), 0);
      end
      if (i < n) begin
        case (mode)
          0: begin x0 = W'($urandom); x1 = W'($urandom); end
          1: begin x0 = W'($urandom); x1 = x0; end
          2: begin x0 = W'(i * 37); x1 = W'(i * 37 + 19); end
          default: begin x0 = W'(FS - 1); x1 = (i % 3 == 0) ? W'(0) : W'(FS - 1); end
        endcase
        e0[i] = ref_step(int'(x0));
        e1[i] = ref_step(int'(x1));
      end
    end
  endtask

  task automatic test_reset_state();
    do_reset();
    @(negedge clk);
    check("R7 valid after one edge", int'(out_valid), 0);
    check("R8 y0 idle", int'(y0), 0);
  endtask

  task automatic test_random();
    do_reset();
    run_seq(300, 0, "random R1 R2");
  endtask

  task automatic test_ramp();
    do_reset();
    run_seq(200, 2, "ramp");
  endtask

  task automatic test_extremes();
    do_reset();
    run_seq(120, 3, "extremes R4");
  endtask

  task automatic test_shorted();
    do_reset();
    run_seq(250, 1, "shorted R9");
  endtask

  task automatic test_full_rate();
    do_reset();
    run_seq(40, 0, "pre");
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #2;
      check("R6 high phase ch0", int'(y_full), int'(y0));
      @(negedge clk); #2;
      check("R6 low phase ch1", int'(y_full), int'(y1));
    end
  endtask

  task automatic test_midrun_reset();
    do_reset();
    run_seq(50, 0, "before");
    do_reset();
    run_seq(60, 0, "R8 after reset");
  endtask

  task automatic test_dc();
    int sum;
    do_reset();
    sum = 0;
    x0 = W'(1000); x1 = W'(1000);
    for (int i = 0; i < 2050; i++) begin
      if (i > 0) @(negedge clk);
      if (i >= 2) sum += int'(y0) + int'(y1);
    end
    checks++;
    if (sum < 1000 - 3 || sum > 1000 + 3) begin
      errors++;
      $display("FAIL R10: actual=%0d expected=%0d", sum, 1000);
    end
  endtask

  initial begin
    void'($urandom(7));
    test_reset_state();
    test_random();
    test_ramp();
    test_extremes();
    test_shorted();
    test_full_rate();
    test_midrun_reset();
    test_dc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule